// File: doc/BRIEF.md
# Shared-Prescaler GPIO Input Debouncer

This unit filters the synchronized inputs of a 32-pin general-purpose port before they reach the port's interrupt detector. A single programmable prescaler divides the bus clock into a sampling tick. Every pin that has filtering switched on uses this same tick. A filtered pin reports a new level only when two consecutive ticks have seen that level on the input. As a result, any pulse shorter than one tick interval never reaches the interrupt path.

Software controls the unit through two 32-bit registers on the port's register bus. The first is a per-pin filter-select mask. The second is the prescale count, which holds the number of bus clock cycles per tick. A pin whose mask bit is clear is not filtered: it passes its synchronized level through with one register of delay. Software picks the prescale count as the bus clock frequency divided by the tick rate it wants. For example, a count of 2000 on a 66 MHz clock gives roughly a 33 kHz tick. Filtering matters only on pins whose interrupts are enabled downstream. The plain data-in readback path never goes through this unit.

Top module: `gpio_debounce_unit`

## Requirements
- R1: The filter-select register is at byte offset 0x40. Bit n controls pin n, with 1 meaning filtered. The register resets to zero and reads back the value written.
- R2: The prescale register is at byte offset 0x44 and holds a 24-bit count in bits 23:0. Writes to bits 31:24 are discarded, and those bits always read as zero. The register resets to zero. Any other offset reads as zero.
- R3: With a prescale count P of 2 or more, a tick occurs once every P bus clock cycles. With P equal to 0 or 1, a tick occurs on every cycle.
- R4: A write to the prescale register restarts the tick counter. The first tick after the write falls on the P-th clock edge after the edge that takes the write.
- R5: On a filtered pin, the output changes only on a tick edge, and only to a level that the input also showed on the previous tick. An input pulse that no two consecutive ticks both see is never passed on.
- R6: On an unfiltered pin, the output equals the synchronized input delayed by exactly one clock cycle. This also holds from the cycle right after the pin's select bit is cleared.
- R7: All filtered pins share the same tick. Pins that change together while filtered therefore update together, on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_sync | input | 32 | Synchronized pin levels |
| dbnc_out | output | 32 | Levels presented to the interrupt detector |

## Verification
The bench runs a sweep of small prescale counts, including 0 and 1, with mixed filter-select masks and input patterns held for varying lengths. It compares every cycle against an arithmetic model, so a prescaler that is off by one would shift the tick edges and show up as mismatches. Directed cases cover the rest:
- A glitch shorter than a tick interval must be rejected. A filter that accepts a single tick would let it through.
- A rise written right after a prescale change must appear exactly ten edges later. A counter that is not restarted on the write would shift this by the old phase.
- A readback after an all-ones write must show bits 31:24 as zero. A register that is too wide would return 0xFF in the top byte.

// File: rtl/gpio_dbnc_pkg.sv
package gpio_dbnc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] OFS_SELECT   = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_PRESCALE = 8'h44;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] ofs);
        return a == ofs;
    endfunction
endpackage

// File: rtl/dbnc_regs.sv
module dbnc_regs
    import gpio_dbnc_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int PRE_W    = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  bus_req_t            req,
    output logic [NUM_PINS-1:0] sel_q,
    output logic [PRE_W-1:0]    pre_q,
    output logic                pre_wr,
    output logic [DATA_W-1:0]   rdata
);
    logic sel_wr;

    always_comb begin
        sel_wr = req.wr && hit(req.addr, OFS_SELECT);
        pre_wr = req.wr && hit(req.addr, OFS_PRESCALE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            pre_q <= '0;
        end else begin
            if (sel_wr) sel_q <= req.wdata[NUM_PINS-1:0];
            if (pre_wr) pre_q <= req.wdata[PRE_W-1:0];
        end
    end

    // Read mux: unused upper bits are zero-filled.
    always_comb begin
        rdata = '0;
        if (hit(req.addr, OFS_SELECT))   rdata[NUM_PINS-1:0] = sel_q;
        if (hit(req.addr, OFS_PRESCALE)) rdata[PRE_W-1:0]    = pre_q;
    end
endmodule

// File: rtl/dbnc_tick_gen.sv
module dbnc_tick_gen #(
    parameter int PRE_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] pre_q,
    input  logic             restart,
    output logic             tick,
    output logic [PRE_W-1:0] cnt_q
);
    logic fast;

    always_comb begin
        fast = pre_q <= PRE_W'(1);
        tick = fast || (cnt_q == pre_q - PRE_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + PRE_W'(1);
    end
endmodule

// File: rtl/dbnc_lane.sv
module dbnc_lane (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic sel,
    input  logic pin,
    output logic samp_q,
    output logic filt_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            filt_q <= 1'b0;
        end else if (!sel) begin
            samp_q <= pin;
            filt_q <= pin;
        end else if (tick) begin
            samp_q <= pin;
            if (pin == samp_q) filt_q <= pin;
        end
    end
endmodule

// File: rtl/gpio_debounce_unit.sv
module gpio_debounce_unit
    import gpio_dbnc_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int PRE_W    = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] dbnc_out
);
    bus_req_t            req;
    logic [NUM_PINS-1:0] sel_q;
    logic [PRE_W-1:0]    pre_q;
    logic [PRE_W-1:0]    cnt_q;
    logic                pre_wr;
    logic                tick;
    logic [NUM_PINS-1:0] samp;

    assign req = '{wr: bus_wr, addr: bus_addr, wdata: bus_wdata};

    dbnc_regs #(.NUM_PINS(NUM_PINS), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst(rst), .req(req), .sel_q(sel_q),
        .pre_q(pre_q), .pre_wr(pre_wr), .rdata(bus_rdata)
    );

    dbnc_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst(rst), .pre_q(pre_q), .restart(pre_wr),
        .tick(tick), .cnt_q(cnt_q)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
        dbnc_lane u_lane (
            .clk(clk), .rst(rst), .tick(tick), .sel(sel_q[i]),
            .pin(pin_sync[i]), .samp_q(samp[i]), .filt_q(dbnc_out[i])
        );
    end
endmodule

// File: rtl/dbnc_checker.sv
module dbnc_checker
    import gpio_dbnc_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int PRE_W    = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] pin_sync,
    input logic [NUM_PINS-1:0] dbnc_out,
    input logic [NUM_PINS-1:0] sel_q,
    input logic [NUM_PINS-1:0] samp,
    input logic [PRE_W-1:0]    pre_q,
    input logic [PRE_W-1:0]    cnt_q,
    input logic                tick
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    AST_PRESCALE_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_PRESCALE) |-> (bus_rdata[DATA_W-1:PRE_W] == '0)); // R2
    AST_FAST_TICK: assert property (@(posedge clk) disable iff (rst)
        (pre_q <= PRE_W'(1)) |-> tick); // R3
    AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_PRESCALE) |=> (cnt_q == '0)); // R4
    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(tick)) |-> (((dbnc_out ^ $past(dbnc_out)) & $past(sel_q)) == '0)); // R5
    AST_TWO_TICK_AGREE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(tick)) |->
        (((dbnc_out ^ $past(dbnc_out)) & $past(sel_q) & ($past(pin_sync) ^ $past(samp))) == '0)); // R5
    AST_BYPASS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (((dbnc_out ^ $past(pin_sync)) & ~$past(sel_q)) == '0)); // R6
endmodule

bind gpio_debounce_unit dbnc_checker #(.NUM_PINS(NUM_PINS), .PRE_W(PRE_W)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .pin_sync(pin_sync), .dbnc_out(dbnc_out),
    .sel_q(sel_q), .samp(samp), .pre_q(pre_q), .cnt_q(cnt_q), .tick(tick)
);

// File: tb/tb_gpio_debounce_unit.sv
module tb_gpio_debounce_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_sync = '0;
    logic [31:0] dbnc_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    gpio_debounce_unit dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_sync(pin_sync), .dbnc_out(dbnc_out)
    );

    // Behavioural expectation built from the requirements.
    int          m_cnt;
    logic [23:0] m_pre;
    logic [31:0] m_sel, m_samp, m_filt;
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_pre = '0; m_sel = '0; m_samp = '0; m_filt = '0;
        end else begin
            logic t;
            t = (m_pre <= 24'd1) || (m_cnt == int'(m_pre) - 1);
            for (int i = 0; i < 32; i++) begin
                if (!m_sel[i]) begin
                    m_filt[i] = pin_sync[i]; m_samp[i] = pin_sync[i];
                end else if (t) begin
                    if (pin_sync[i] == m_samp[i]) m_filt[i] = pin_sync[i];
                    m_samp[i] = pin_sync[i];
                end
            end
            if (bus_wr && bus_addr == 8'h44) begin
                m_pre = bus_wdata[23:0]; m_cnt = 0;
            end else if (t) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            if (bus_wr && bus_addr == 8'h40) m_sel = bus_wdata;
        end
    end

    // Per-cycle comparison: R3 R4 R5 R6 R7
    always @(negedge clk) begin
        if (!rst) begin
            n_checks++;
            if (dbnc_out !== m_filt) begin
                n_fail++;
                $display("FAIL R3/R4/R5/R6/R7 cycle compare: actual %h expected %h", dbnc_out, m_filt);
            end
        end
    end

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] x;
        x = v ^ (v << 13);
        x = x ^ (x >> 17);
        return x ^ (x << 5);
    endfunction

    initial begin
        logic [31:0] rd;
        logic [31:0] lfsr;
        int          pres [6];
        pres = '{0, 1, 2, 3, 5, 7};
        lfsr = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd_reg(8'h40, rd); check32("R1 select reset", rd, 32'h0);
        rd_reg(8'h44, rd); check32("R2 prescale reset", rd, 32'h0);
        check32("R6 output after reset", dbnc_out, 32'h0);
        @(negedge clk);
        wr_reg(8'h44, 32'hFFFF_FFFF);
        rd_reg(8'h44, rd); check32("R2 top byte ignored", rd, 32'h00FF_FFFF);
        wr_reg(8'h40, 32'hA5C3_0F96);
        rd_reg(8'h40, rd); check32("R1 select readback", rd, 32'hA5C3_0F96);
        rd_reg(8'h48, rd); check32("R2 unmapped offset", rd, 32'h0);

        // Sweep of prescale counts, hold lengths and select masks.
        for (int p = 0; p < 6; p++) begin
            int hold;
            hold = 2 * p + 1;
            wr_reg(8'h44, pres[p]);
            lfsr = xs(lfsr);
            wr_reg(8'h40, lfsr);
            for (int c = 0; c < 320; c++) begin
                if (c % hold == 0) begin lfsr = xs(lfsr); pin_sync = lfsr; end
                if (c == 160) begin lfsr = xs(lfsr); wr_reg(8'h40, lfsr); end
                else @(negedge clk);
            end
            rd_reg(8'h44, rd); check32("R2 prescale readback", rd, pres[p]);
        end

        // Restart timing: rise seen on edges w+5 and w+10.
        wr_reg(8'h40, 32'hFFFF_FFFF);
        pin_sync = '0;
        repeat (20) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h44; bus_wdata = 32'd5;
        @(negedge clk);
        bus_wr = 1'b0;
        pin_sync = 32'hFFFF_FFFF;
        repeat (9) @(negedge clk);
        check32("R4 no change before second tick", dbnc_out, 32'h0);
        @(negedge clk);
        check32("R4 R7 all pins rise on same tick", dbnc_out, 32'hFFFF_FFFF);

        // Glitch shorter than one tick interval is rejected.
        wr_reg(8'h44, 32'd8);
        pin_sync = '0;
        repeat (30) @(negedge clk);
        check32("R5 settle low", dbnc_out, 32'h0);
        wr_reg(8'h44, 32'd8);
        pin_sync = 32'h0F0F_F0F0;
        repeat (3) @(negedge clk);
        pin_sync = '0;
        repeat (30) @(negedge clk);
        check32("R5 glitch rejected", dbnc_out, 32'h0);

        // Clear select: follow input next cycle.
        pin_sync = 32'h1357_9BDF;
        wr_reg(8'h40, 32'h0);
        @(negedge clk);
        check32("R6 bypass after clear", dbnc_out, 32'h1357_9BDF);
        pin_sync = 32'hFEDC_BA98;
        @(negedge clk);
        check32("R6 one cycle delay", dbnc_out, 32'hFEDC_BA98);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule